// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the strobe lines of an asynchronous, multiplexed-address DRAM array whenever the array has to be woken up or refreshed. It runs from a system clock of known period. Every analog timing limit is turned into a whole number of clock cycles when the block is elaborated. After reset it keeps the array quiet for the start-up delay. It then runs a fixed number of warm-up refresh cycles and only after that raises a ready flag for the access controller.

Once ready, an interval timer earns one refresh credit per average refresh period, so that every row is covered within the retention window. Credits are kept in a bounded backlog. The block asks for the bus with a request line and starts a cycle only when the access controller grants it. A page burst that runs long only postpones refreshes, and the missed ones are issued back-to-back later. Each refresh is a column-before-row cycle: the column strobes go low first, the row strobe follows, and write enable stays high throughout.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is high and on the cycle after it, ras_n, every cas_n bit and we_n are 1, and rfsh_req, rfsh_busy and mem_ready are 0.
- R2: For the first STARTUP cycles after reset is released (20000 cycles at 10 ns, 200 us), ras_n and cas_n stay high and rfsh_req stays low.
- R3: After the start-up delay, exactly INIT_REFRESHES (default 8) refresh cycles are performed before mem_ready rises. Once high, mem_ready stays high until reset.
- R4: In every refresh cycle all cas_n bits move together, and they are low for at least ceil(10 ns / period) cycles before ras_n falls. ras_n never falls while cas_n is high.
- R5: cas_n stays low for at least ceil(10 ns / period) cycles after ras_n falls.
- R6: ras_n stays low for at least ceil(60 ns / period) cycles. Between two refresh cycles it stays high for at least ceil(40 ns / period) cycles, with cas_n also high for that time.
- R7: we_n is never driven low.
- R8: Once ready, one refresh credit is earned every floor((32 ms / 2048) / period) cycles (1562 at 10 ns). With the grant held high, N periods yield N refresh cycles.
- R9: A refresh starts only on a cycle where rfsh_req and rfsh_gnt are both high. While the grant is withheld, no refresh starts, and rfsh_req stays high once a credit is waiting.
- R10: The backlog holds at most MAX_PENDING (default 8) credits and further credits are dropped. When the grant returns, all stored credits are issued back-to-back.
- R11: rfsh_busy is high during every cycle in which ras_n or cas_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, period CLK_PERIOD_PS |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Access controller grants the bus for a refresh |
| rfsh_req | output | 1 | A refresh (warm-up or periodic) is waiting for the bus |
| rfsh_busy | output | 1 | A refresh cycle owns the DRAM strobes |
| mem_ready | output | 1 | Start-up delay and warm-up refreshes are complete |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | NUM_CAS | Active-low column strobes, all driven alike |
| we_n | output | 1 | Active-low write enable, held high |

## Verification
The bench withholds the grant for 1, 2, 3, 8 and 11 refresh periods and then counts the burst that follows. A backlog that drops credits, fails to saturate or overflows its counter would give a burst of the wrong length. The same windows check that nothing starts without a grant; a sequencer that ignored the handshake would drive the row strobe in the middle of a page burst. A monitor measures strobe ordering and pulse widths on every cycle. It would catch a row strobe that falls before the column strobes, a pulse cut one cycle short, or write enable dipping into test-mode entry. A mid-run reset checks that the start-up wait and the count of eight warm-up refreshes start over.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_PRECHG
  } cbr_phase_e;

  // Minimum timing in ns -> whole cycles, rounded up, at least one.
  function automatic int unsigned cycles_ceil(longint unsigned ns, longint unsigned clk_ps);
    longint unsigned c;
    c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  // Maximum spacing in ns -> whole cycles, rounded down, at least one.
  function automatic int unsigned cycles_floor(longint unsigned ns, longint unsigned clk_ps);
    longint unsigned c;
    c = (ns * 64'd1000) / clk_ps;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(INTERVAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned MAX_PENDING = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic take,
  output logic pending
);
  localparam int unsigned CW = $clog2(MAX_PENDING + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_PENDING);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({add, take})
        2'b10:   if (count != FULL) count <= count + 1'b1;
        2'b01:   if (count != '0)   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign pending = (count != '0);

  assert_backlog_saturates_R10: assert property (@(posedge clk) disable iff (rst)
    (add && !take && count == FULL) |=> count == FULL);

  assert_take_has_credit_R10: assert property (@(posedge clk) disable iff (rst)
    take |-> count != '0);

endmodule

// File: rtl/cbr_engine.sv
module cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned N_CSR  = 1,
  parameter int unsigned N_CHR  = 1,
  parameter int unsigned N_HOLD = 6,
  parameter int unsigned N_PRE  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(max2(max2(N_CSR, N_HOLD), N_PRE) + 2);
  localparam logic [CW-1:0] LAST_CSR  = CW'(N_CSR - 1);
  localparam logic [CW-1:0] LAST_CHR  = CW'(N_CHR - 1);
  localparam logic [CW-1:0] LAST_HOLD = CW'(N_HOLD - 1);
  localparam logic [CW-1:0] LAST_PRE  = CW'(N_PRE - 1);

  cbr_phase_e    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      we_n <= 1'b1;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= '0;
          cas_n <= 1'b0;
          busy  <= 1'b1;
        end
        PH_SETUP: if (cnt == LAST_CSR) begin
          phase <= PH_STROBE;
          cnt   <= '0;
          ras_n <= 1'b0;
        end else cnt <= cnt + 1'b1;
        PH_STROBE: begin
          if (cnt == LAST_CHR) cas_n <= 1'b1;
          if (cnt == LAST_HOLD) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            phase <= PH_PRECHG;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_PRECHG: if (cnt == LAST_PRE) begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Checker: independent run-length counters on the strobe outputs.
  localparam logic [CW-1:0] SAT = '1;
  logic [CW-1:0] ras_low_run, ras_high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_low_run  <= '0;
      ras_high_run <= SAT;
    end else if (!ras_n) begin
      ras_high_run <= '0;
      if (ras_low_run != SAT) ras_low_run <= ras_low_run + 1'b1;
    end else begin
      ras_low_run <= '0;
      if (ras_high_run != SAT) ras_high_run <= ras_high_run + 1'b1;
    end
  end

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_ras_width_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras_n) && !$past(rst)) |-> ras_low_run >= CW'(N_HOLD));

  assert_precharge_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ras_high_run >= CW'(N_PRE));

  assert_busy_covers_R11: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> busy);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS     = 10000,
  parameter int unsigned STARTUP_NS        = 200000,
  parameter int unsigned INIT_REFRESHES    = 8,
  parameter int unsigned REFRESH_WINDOW_NS = 32000000,
  parameter int unsigned REFRESH_ROWS      = 2048,
  parameter int unsigned T_CSR_NS          = 10,
  parameter int unsigned T_CHR_NS          = 10,
  parameter int unsigned T_RAS_NS          = 60,
  parameter int unsigned T_RP_NS           = 40,
  parameter int unsigned T_CRP_NS          = 5,
  parameter int unsigned MAX_PENDING       = 8,
  parameter int unsigned NUM_CAS           = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rfsh_gnt,
  output logic               rfsh_req,
  output logic               rfsh_busy,
  output logic               mem_ready,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               we_n
);
  localparam int unsigned STARTUP_CYC  = cycles_ceil(STARTUP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CSR        = cycles_ceil(T_CSR_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CHR        = cycles_ceil(T_CHR_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RAS        = cycles_ceil(T_RAS_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RP         = cycles_ceil(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CRP        = cycles_ceil(T_CRP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_HOLD       = max2(N_RAS, N_CHR);
  localparam int unsigned N_PRE        = max2(N_RP, N_CRP);
  localparam int unsigned INTERVAL_CYC = cycles_floor(REFRESH_WINDOW_NS / REFRESH_ROWS, CLK_PERIOD_PS);
  localparam int unsigned SW = $clog2(STARTUP_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);
  localparam logic [SW-1:0] UP_LAST   = SW'(STARTUP_CYC - 1);
  localparam logic [IW-1:0] INIT_ALL  = IW'(INIT_REFRESHES);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFRESHES - 1);

  logic [SW-1:0] up_cnt;
  logic          powered_up;
  logic [IW-1:0] init_started, init_done;
  logic          start, want, tick, pending;
  logic          eng_ras_n, eng_cas_n, eng_we_n, eng_busy, eng_done;

  // Start-up delay: counts once after reset, then stays done.
  always_ff @(posedge clk) begin
    if (rst) begin
      up_cnt     <= '0;
      powered_up <= 1'b0;
    end else if (!powered_up) begin
      if (up_cnt == UP_LAST) powered_up <= 1'b1;
      else                   up_cnt     <= up_cnt + 1'b1;
    end
  end

  assign start = rfsh_req && rfsh_gnt;
  assign want  = mem_ready ? pending : (powered_up && init_started != INIT_ALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      rfsh_req     <= 1'b0;
      mem_ready    <= 1'b0;
      init_started <= '0;
      init_done    <= '0;
    end else begin
      rfsh_req <= want && !start && !eng_busy;
      if (start && !mem_ready) init_started <= init_started + 1'b1;
      if (eng_done && !mem_ready) begin
        if (init_done == INIT_LAST) mem_ready <= 1'b1;
        else                        init_done <= init_done + 1'b1;
      end
    end
  end

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(mem_ready), .tick(tick)
  );

  rfsh_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
    .clk(clk), .rst(rst), .add(tick), .take(start && mem_ready), .pending(pending)
  );

  cbr_engine #(.N_CSR(N_CSR), .N_CHR(N_CHR), .N_HOLD(N_HOLD), .N_PRE(N_PRE)) u_engine (
    .clk(clk), .rst(rst), .start(start),
    .ras_n(eng_ras_n), .cas_n(eng_cas_n), .we_n(eng_we_n),
    .busy(eng_busy), .done(eng_done)
  );

  assign ras_n     = eng_ras_n;
  assign cas_n     = {NUM_CAS{eng_cas_n}};
  assign we_n      = eng_we_n;
  assign rfsh_busy = eng_busy;

  assert_quiet_startup_R2: assert property (@(posedge clk) disable iff (rst)
    !powered_up |-> (eng_ras_n && eng_cas_n));

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(mem_ready));

  assert_ready_after_startup_R3: assert property (@(posedge clk) disable iff (rst)
    mem_ready |-> powered_up);

  assert_start_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_cas_n) |-> ($past(rfsh_gnt) && $past(rfsh_req)));

endmodule

// File: tb/dram_rfsh_seq_tb.sv
module dram_rfsh_seq_tb;
  localparam int STARTUP = 20000;
  localparam int PERIOD  = 1562;
  localparam int N_CSR   = 1;
  localparam int N_CHR   = 1;
  localparam int N_RAS   = 6;
  localparam int N_RP    = 4;
  localparam int N_INIT  = 8;
  localparam int NV      = 5;
  localparam int VEC_HOLD[NV] = '{1, 3, 8, 11, 2};
  localparam int VEC_EXP [NV] = '{1, 3, 8, 8, 2};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rfsh_gnt = 1'b1;
  logic       rfsh_req, rfsh_busy, mem_ready, ras_n, we_n;
  logic [3:0] cas_n;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, falls = 0, ready_cyc = 0, init_falls = 0, fall_cyc = 0;
  int cas_run = 0, ras_low_run = 0, ras_high_run = 1000;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_ready = 1'b0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r11 = 0;

  always #5 clk = ~clk;

  dram_rfsh_seq u_dut (
    .clk(clk), .rst(rst), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
    .rfsh_busy(rfsh_busy), .mem_ready(mem_ready), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Monitor samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; falls = 0; cas_run = 0; ras_low_run = 0; ras_high_run = 1000;
      prev_ras = 1'b1; prev_cas = 1'b1; prev_ready = 1'b0;
    end else begin
      cyc++;
      if (cyc < STARTUP && (!ras_n || cas_n != 4'hF || rfsh_req)) v_r2++;
      if (prev_ready && !mem_ready) v_r3++;
      if (!prev_ready && mem_ready) begin ready_cyc = cyc; init_falls = falls; end
      if (!we_n) v_r7++;
      if (cas_n != 4'h0 && cas_n != 4'hF) v_r4++;
      if ((!ras_n || !cas_n[0]) && !rfsh_busy) v_r11++;
      if (prev_ras && !ras_n) begin
        falls++;
        fall_cyc = cyc;
        if (cas_n[0] || cas_run < N_CSR) v_r4++;
        if (ras_high_run < N_RP) v_r6++;
      end
      if (!prev_ras && ras_n && ras_low_run < N_RAS) v_r6++;
      if (!prev_cas && cas_n[0] && (cyc - fall_cyc) < N_CHR) v_r5++;
      cas_run      = cas_n[0] ? 0 : cas_run + 1;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      prev_ras = ras_n; prev_cas = cas_n[0]; prev_ready = mem_ready;
    end
  end

  task automatic check_reset_state();
    chk(ras_n == 1'b1, "R1 ras_n", int'(ras_n), 1);
    chk(cas_n == 4'hF, "R1 cas_n", int'(cas_n), 15);
    chk(we_n == 1'b1, "R1 we_n", int'(we_n), 1);
    chk({rfsh_req, rfsh_busy, mem_ready} == 3'b000, "R1 req/busy/ready",
        int'({rfsh_req, rfsh_busy, mem_ready}), 0);
  endtask

  task automatic wait_ready();
    while (!mem_ready) step(1);
    step(1);
    chk(init_falls == N_INIT, "R3 warm-up refresh count", init_falls, N_INIT);
    chk(ready_cyc >= STARTUP, "R2 ready after start-up delay", ready_cyc, STARTUP);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0;
    step(4);
    check_reset_state();                       // R1 during reset
    rst = 1'b0;
    step(1);
    check_reset_state();                       // R1 first cycle after reset
    wait_ready();                              // R2, R3

    // Align to the middle of a refresh period.
    while (cyc < ready_cyc + PERIOD + 400) step(1);
    f0 = falls;
    step(5 * PERIOD);
    chk(falls - f0 == 5, "R8 refreshes over 5 periods", falls - f0, 5);

    // Vector table: withhold grant k periods, then count the burst.
    for (int i = 0; i < NV; i++) begin
      rfsh_gnt = 1'b0;
      f0 = falls;
      step(VEC_HOLD[i] * PERIOD);
      chk(falls == f0, "R9 no refresh without grant", falls - f0, 0);
      chk(rfsh_req == 1'b1, "R9 request held while waiting", int'(rfsh_req), 1);
      rfsh_gnt = 1'b1;
      f0 = falls;
      step(700);
      chk(falls - f0 == VEC_EXP[i], "R10 backlog burst length", falls - f0, VEC_EXP[i]);
      step(PERIOD - 700);
    end

    // Directed: reset mid-run restarts delay and warm-up.
    rst = 1'b1;
    step(5);
    check_reset_state();
    rst = 1'b0;
    step(1);
    check_reset_state();
    wait_ready();
    step(50);

    chk(v_r2 == 0, "R2 strobe/request during start-up", v_r2, 0);
    chk(v_r3 == 0, "R3 ready dropped", v_r3, 0);
    chk(v_r4 == 0, "R4 column-before-row ordering", v_r4, 0);
    chk(v_r5 == 0, "R5 column hold after row fall", v_r5, 0);
    chk(v_r6 == 0, "R6 row pulse/precharge width", v_r6, 0);
    chk(v_r7 == 0, "R7 write enable low", v_r7, 0);
    chk(v_r11 == 0, "R11 busy not covering strobes", v_r11, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule